// File: doc/BRIEF.md
# CAN Mailbox Buffer Manager

This block holds outgoing and incoming CAN messages on behalf of a protocol core. On the transmit side, the host writes an identifier and a payload into one of three mailboxes. From that moment the mailbox counts as pending. The manager presents exactly one pending mailbox to the core at a time. The core reports completion with a single-cycle done strobe, and that strobe frees the mailbox. A configuration bit picks which pending mailbox is presented: the one holding the smallest identifier, or the one whose request is oldest.

On the receive side, the core offers each received message with a valid strobe, and the message goes into a three-entry first-in first-out store. The host sees the oldest entry and removes it with a pop strobe. When a message arrives and the store is full, a second configuration bit picks what happens. In the first mode, the newest stored entry is replaced. In the second mode, the store keeps its contents and the arrival is lost. In both modes a sticky loss flag is raised, and the host clears it by pulsing a clear input. Wire-level timing, framing, checksums and bus arbitration belong to the core and are not modelled here.

Top module: `can_mbox_mgr`

## Requirements
- R1: After reset, no mailbox is pending, `tx_valid` and `rd_valid` are 0, `rx_count` is 0 and `ovr_flag` is 0.
- R2: A load strobe aimed at an empty mailbox (index 0 to 2) stores the identifier and payload and makes that mailbox pending from the next cycle. A load aimed at a pending mailbox, or at index 3, changes nothing.
- R3: With `cfg_tx_by_order` = 0, the presented mailbox is the pending one with the numerically smallest identifier. When identifiers are equal, the lower mailbox index is presented.
- R4: With `cfg_tx_by_order` = 1, pending mailboxes are presented in the order in which their loads were accepted. This order survives a load and a done that happen in the same cycle.
- R5: `tx_done` while `tx_valid` is high clears the presented mailbox in the next cycle. Without `tx_done`, no pending mailbox becomes empty. `tx_valid` is high exactly when some mailbox is pending.
- R6: The receive store returns messages oldest first and holds up to 3 of them. `rd_id`/`rd_data` show the oldest entry, `rx_count` gives the occupancy, and `rd_pop` on an empty store has no effect.
- R7: With `cfg_rx_lock` = 0, an arrival into a full store replaces the newest entry. After arrivals 1 to 5 with no pops, the store holds 1, 2, 5.
- R8: With `cfg_rx_lock` = 1, an arrival into a full store is dropped. After arrivals 1 to 5 with no pops, the store holds 1, 2, 3.
- R9: Every replaced or dropped arrival sets `ovr_flag`, which stays set until `ovr_clr` is pulsed. If a loss and a clear fall in the same cycle, the flag stays set.
- R10: An arrival and a pop in the same cycle on a full store lose nothing. The oldest entry leaves, the arrival enters, and the flag is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tx_by_order | input | 1 | 1: request-order selection, 0: smallest identifier first |
| cfg_rx_lock | input | 1 | 1: drop arrivals when full, 0: replace newest entry |
| ld_valid | input | 1 | Load strobe for a mailbox |
| ld_idx | input | 2 | Target mailbox index |
| ld_id | input | 11 | Identifier to load |
| ld_data | input | 64 | Payload to load |
| mbox_pending | output | 3 | Pending bit per mailbox |
| tx_valid | output | 1 | A mailbox is presented to the core |
| tx_idx | output | 2 | Index of the presented mailbox |
| tx_id | output | 11 | Identifier of the presented mailbox |
| tx_data | output | 64 | Payload of the presented mailbox |
| tx_done | input | 1 | Core finished the presented mailbox |
| rx_valid | input | 1 | Core delivers a received message |
| rx_id | input | 11 | Received identifier |
| rx_data | input | 64 | Received payload |
| rd_valid | output | 1 | Receive store not empty |
| rd_id | output | 11 | Identifier of the oldest stored message |
| rd_data | output | 64 | Payload of the oldest stored message |
| rd_pop | input | 1 | Remove the oldest stored message |
| rx_count | output | 2 | Number of stored messages |
| ovr_flag | output | 1 | Sticky loss flag |
| ovr_clr | input | 1 | Clear the loss flag |

## Verification
The bench targets identifier ties, which a wrong comparison would resolve toward the higher index. It targets a load and a done landing in the same cycle in request-order mode, where a bad age update would present the new mailbox ahead of an older one or present two heads. It runs the five-arrival sequence in both full-store modes: a design that replaces the wrong slot ends up with 1, 2, 5 in the wrong places or loses message 1. It also drives a pop and an arrival together on a full store, which a design that checks fullness before the pop would wrongly count as a loss. Pops on an empty store, loads into busy mailboxes, and a clear that collides with a loss are each compared against the reference model every cycle.

// File: rtl/can_mbox_pkg.sv
`timescale 1ns/1ps
package can_mbox_pkg;
    localparam int unsigned CAN_ID_W   = 11;
    localparam int unsigned CAN_DATA_W = 64;

    typedef struct packed {
        logic [CAN_ID_W-1:0]   id;
        logic [CAN_DATA_W-1:0] data;
    } can_msg_t;
endpackage

// File: rtl/can_tx_sel.sv
`timescale 1ns/1ps
module can_tx_sel
    import can_mbox_pkg::*;
#(
    parameter int unsigned NUM_MBOX = 3
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       cfg_req_order,
    input  logic                                       ld_valid,
    input  logic [((NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1)-1:0] ld_idx,
    input  can_msg_t                                   ld_msg,
    input  logic                                       tx_done,
    output logic                                       tx_valid,
    output logic [((NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1)-1:0] tx_idx,
    output can_msg_t                                   tx_msg,
    output logic [NUM_MBOX-1:0]                        pending
);
    localparam int unsigned IDX_W = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1;
    localparam int unsigned CNT_W = $clog2(NUM_MBOX + 1);
    localparam logic [IDX_W:0] NUM_L = (IDX_W + 1)'(NUM_MBOX);

    typedef struct packed {
        logic [NUM_MBOX-1:0]            pend;
        logic [NUM_MBOX-1:0][IDX_W-1:0] rank;
        can_msg_t [NUM_MBOX-1:0]        msg;
    } sel_state_t;

    sel_state_t            st_q, st_d;
    logic [IDX_W-1:0]      id_pick, ord_pick, pick;
    logic [CAN_ID_W-1:0]   best_id;
    logic                  found;
    logic [NUM_MBOX-1:0]   head_vec;
    logic [NUM_MBOX-1:0]   below_vec;
    logic [CNT_W-1:0]      n_pend;
    logic                  done_hit;
    logic                  ld_ok;

    // per-mailbox head marker (age rank zero)
    for (genvar g = 0; g < NUM_MBOX; g++) begin : g_head
        assign head_vec[g]  = st_q.pend[g] && (st_q.rank[g] == '0);
        assign below_vec[g] = st_q.pend[g] && (st_q.msg[g].id < tx_msg.id);
    end

    // selection under both policies
    always_comb begin
        id_pick  = '0;
        best_id  = '1;
        found    = 1'b0;
        ord_pick = '0;
        n_pend   = '0;
        for (int i = 0; i < NUM_MBOX; i++) begin
            if (st_q.pend[i] && (!found || (st_q.msg[i].id < best_id))) begin
                found   = 1'b1;
                best_id = st_q.msg[i].id;
                id_pick = IDX_W'(i);
            end
            if (head_vec[i]) begin
                ord_pick = IDX_W'(i);
            end
            n_pend = n_pend + CNT_W'(st_q.pend[i]);
        end
        pick = cfg_req_order ? ord_pick : id_pick;
    end

    assign tx_valid = |st_q.pend;
    assign tx_idx   = pick;
    assign tx_msg   = st_q.msg[pick];
    assign pending  = st_q.pend;
    assign done_hit = tx_done && tx_valid;
    assign ld_ok    = ld_valid && ({1'b0, ld_idx} < NUM_L) && !st_q.pend[ld_idx];

    // next-state
    always_comb begin
        st_d = st_q;
        if (done_hit) begin
            st_d.pend[pick] = 1'b0;
            for (int i = 0; i < NUM_MBOX; i++) begin
                if (st_q.pend[i] && (st_q.rank[i] > st_q.rank[pick])) begin
                    st_d.rank[i] = st_q.rank[i] - IDX_W'(1);
                end
            end
        end
        if (ld_ok) begin
            st_d.pend[ld_idx] = 1'b1;
            st_d.msg[ld_idx]  = ld_msg;
            st_d.rank[ld_idx] = IDX_W'(n_pend - CNT_W'(done_hit));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_ID_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !cfg_req_order) |-> (below_vec == '0)); // R3
    AST_ONE_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_q.pend) |-> ($countones(head_vec) == 1)); // R4
    AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && tx_valid) |=> !st_q.pend[$past(tx_idx)]); // R5
    AST_NO_SPONT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_done |=> ((st_q.pend & $past(st_q.pend)) == $past(st_q.pend))); // R5
endmodule

// File: rtl/can_rx_fifo.sv
`timescale 1ns/1ps
module can_rx_fifo
    import can_mbox_pkg::*;
#(
    parameter int unsigned DEPTH = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_lock,
    input  logic                         push,
    input  can_msg_t                     push_msg,
    input  logic                         pop,
    input  logic                         ovr_clr,
    output logic                         head_valid,
    output can_msg_t                     head_msg,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         ovr
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0] DEPTH_S = SUM_W'(DEPTH);
    localparam logic [CNT_W-1:0] FULL_C  = CNT_W'(DEPTH);

    typedef struct packed {
        can_msg_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]     head;
        logic [CNT_W-1:0]     cnt;
        logic                 ovr;
    } fifo_state_t;

    fifo_state_t      st_q, st_d;
    logic             do_pop;
    logic             lost;
    logic [CNT_W-1:0] cnt_a;
    logic [PTR_W-1:0] head_a;

    function automatic logic [PTR_W-1:0] wrap_idx(input logic [SUM_W-1:0] v);
        return (v >= DEPTH_S) ? PTR_W'(v - DEPTH_S) : PTR_W'(v);
    endfunction

    always_comb begin
        st_d   = st_q;
        lost   = 1'b0;
        do_pop = pop && (st_q.cnt != '0);
        cnt_a  = st_q.cnt - CNT_W'(do_pop);
        head_a = do_pop ? wrap_idx(SUM_W'(st_q.head) + SUM_W'(1)) : st_q.head;
        if (push) begin
            if (SUM_W'(cnt_a) < DEPTH_S) begin
                st_d.mem[wrap_idx(SUM_W'(head_a) + SUM_W'(cnt_a))] = push_msg;
                cnt_a = cnt_a + CNT_W'(1);
            end else begin
                lost = 1'b1;
                if (!cfg_lock) begin
                    st_d.mem[wrap_idx(SUM_W'(head_a) + DEPTH_S - SUM_W'(1))] = push_msg;
                end
            end
        end
        st_d.head = head_a;
        st_d.cnt  = cnt_a;
        st_d.ovr  = (st_q.ovr && !ovr_clr) || lost;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_valid = (st_q.cnt != '0);
    assign head_msg   = st_q.mem[st_q.head];
    assign count      = st_q.cnt;
    assign ovr        = st_q.ovr;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_C); // R6
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (!head_valid && pop && !push) |=> !head_valid); // R6
    AST_KEEP_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_lock && push && !pop && count == FULL_C) |=> ($stable(head_msg) && count == FULL_C)); // R7
    AST_LOCK_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lock && push && !pop && count == FULL_C) |=> $stable(st_q.mem)); // R8
    AST_LOSS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && count == FULL_C) |=> ovr); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr); // R9
    AST_SWAP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && count == FULL_C) |=> (count == FULL_C)); // R10
endmodule

// File: rtl/can_mbox_mgr.sv
`timescale 1ns/1ps
module can_mbox_mgr
    import can_mbox_pkg::*;
#(
    parameter int unsigned NUM_MBOX   = 3,
    parameter int unsigned FIFO_DEPTH = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_tx_by_order,
    input  logic                              cfg_rx_lock,
    input  logic                              ld_valid,
    input  logic [$clog2(NUM_MBOX)-1:0]       ld_idx,
    input  logic [CAN_ID_W-1:0]               ld_id,
    input  logic [CAN_DATA_W-1:0]             ld_data,
    output logic [NUM_MBOX-1:0]               mbox_pending,
    output logic                              tx_valid,
    output logic [$clog2(NUM_MBOX)-1:0]       tx_idx,
    output logic [CAN_ID_W-1:0]               tx_id,
    output logic [CAN_DATA_W-1:0]             tx_data,
    input  logic                              tx_done,
    input  logic                              rx_valid,
    input  logic [CAN_ID_W-1:0]               rx_id,
    input  logic [CAN_DATA_W-1:0]             rx_data,
    output logic                              rd_valid,
    output logic [CAN_ID_W-1:0]               rd_id,
    output logic [CAN_DATA_W-1:0]             rd_data,
    input  logic                              rd_pop,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]   rx_count,
    output logic                              ovr_flag,
    input  logic                              ovr_clr
);
    can_msg_t ld_msg, tx_msg, rx_msg, rd_msg;

    assign ld_msg  = '{id: ld_id, data: ld_data};
    assign rx_msg  = '{id: rx_id, data: rx_data};
    assign tx_id   = tx_msg.id;
    assign tx_data = tx_msg.data;
    assign rd_id   = rd_msg.id;
    assign rd_data = rd_msg.data;

    can_tx_sel #(.NUM_MBOX(NUM_MBOX)) u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_req_order (cfg_tx_by_order),
        .ld_valid      (ld_valid),
        .ld_idx        (ld_idx),
        .ld_msg        (ld_msg),
        .tx_done       (tx_done),
        .tx_valid      (tx_valid),
        .tx_idx        (tx_idx),
        .tx_msg        (tx_msg),
        .pending       (mbox_pending)
    );

    can_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_lock   (cfg_rx_lock),
        .push       (rx_valid),
        .push_msg   (rx_msg),
        .pop        (rd_pop),
        .ovr_clr    (ovr_clr),
        .head_valid (rd_valid),
        .head_msg   (rd_msg),
        .count      (rx_count),
        .ovr        (ovr_flag)
    );
endmodule

// File: tb/tb_can_mbox_mgr.sv
`timescale 1ns/1ps
module tb_can_mbox_mgr;
    localparam int NM = 3;
    localparam int FD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_tx_by_order = 1'b0, cfg_rx_lock = 1'b0;
    logic        ld_valid = 1'b0;
    logic [1:0]  ld_idx = '0;
    logic [10:0] ld_id = '0;
    logic [63:0] ld_data = '0;
    logic [2:0]  mbox_pending;
    logic        tx_valid;
    logic [1:0]  tx_idx;
    logic [10:0] tx_id;
    logic [63:0] tx_data;
    logic        tx_done = 1'b0;
    logic        rx_valid = 1'b0;
    logic [10:0] rx_id = '0;
    logic [63:0] rx_data = '0;
    logic        rd_valid;
    logic [10:0] rd_id;
    logic [63:0] rd_data;
    logic        rd_pop = 1'b0;
    logic [1:0]  rx_count;
    logic        ovr_flag;
    logic        ovr_clr = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    can_mbox_mgr dut (
        .clk(clk), .rst_n(rst_n), .cfg_tx_by_order(cfg_tx_by_order), .cfg_rx_lock(cfg_rx_lock),
        .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_id(ld_id), .ld_data(ld_data),
        .mbox_pending(mbox_pending), .tx_valid(tx_valid), .tx_idx(tx_idx), .tx_id(tx_id),
        .tx_data(tx_data), .tx_done(tx_done), .rx_valid(rx_valid), .rx_id(rx_id),
        .rx_data(rx_data), .rd_valid(rd_valid), .rd_id(rd_id), .rd_data(rd_data),
        .rd_pop(rd_pop), .rx_count(rx_count), .ovr_flag(ovr_flag), .ovr_clr(ovr_clr)
    );

    // reference model state
    bit          m_pend [NM];
    logic [10:0] m_id   [NM];
    logic [63:0] m_data [NM];
    int          m_ord  [$];
    logic [10:0] f_id   [$];
    logic [63:0] f_data [$];
    bit          m_ovr;
    int          s_pick;
    bit          pb     [NM];
    bit          m_lost;

    function automatic int model_pick();
        int best = -1;
        if (cfg_tx_by_order) return (m_ord.size() > 0) ? m_ord[0] : -1;
        for (int i = 0; i < NM; i++)
            if (m_pend[i] && (best < 0 || m_id[i] < m_id[best])) best = i;
        return best;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NM; i++) m_pend[i] = 1'b0;
            m_ord.delete(); f_id.delete(); f_data.delete(); m_ovr = 1'b0;
        end else begin
            s_pick = model_pick();
            for (int i = 0; i < NM; i++) pb[i] = m_pend[i];
            if (tx_done && s_pick >= 0) begin
                m_pend[s_pick] = 1'b0;
                for (int k = 0; k < m_ord.size(); k++)
                    if (m_ord[k] == s_pick) begin m_ord.delete(k); break; end
            end
            if (ld_valid && ld_idx < 2'(NM) && !pb[ld_idx]) begin
                m_pend[ld_idx] = 1'b1;
                m_id[ld_idx]   = ld_id;
                m_data[ld_idx] = ld_data;
                m_ord.push_back(int'(ld_idx));
            end
            m_lost = 1'b0;
            if (rd_pop && f_id.size() > 0) begin
                void'(f_id.pop_front()); void'(f_data.pop_front());
            end
            if (rx_valid) begin
                if (f_id.size() < FD) begin
                    f_id.push_back(rx_id); f_data.push_back(rx_data);
                end else begin
                    m_lost = 1'b1;
                    if (!cfg_rx_lock) begin
                        f_id[f_id.size()-1]     = rx_id;
                        f_data[f_data.size()-1] = rx_data;
                    end
                end
            end
            m_ovr = (m_ovr && !ovr_clr) || m_lost;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int p;
        logic [2:0] ev;
        p = model_pick();
        chk(tx_valid == (p >= 0), "R5", "tx_valid", 64'(tx_valid), 64'(p >= 0));
        if (p >= 0 && tx_valid) begin
            chk(tx_idx == 2'(p), cfg_tx_by_order ? "R4" : "R3", "tx_idx", 64'(tx_idx), 64'(p));
            chk(tx_id == m_id[p], "R2", "tx_id", 64'(tx_id), 64'(m_id[p]));
            chk(tx_data == m_data[p], "R2", "tx_data", tx_data, m_data[p]);
        end
        for (int i = 0; i < NM; i++) ev[i] = m_pend[i];
        chk(mbox_pending == ev, "R5", "pending", 64'(mbox_pending), 64'(ev));
        chk(rd_valid == (f_id.size() > 0), "R6", "rd_valid", 64'(rd_valid), 64'(f_id.size() > 0));
        if (f_id.size() > 0 && rd_valid) begin
            chk(rd_id == f_id[0], "R6", "rd_id", 64'(rd_id), 64'(f_id[0]));
            chk(rd_data == f_data[0], "R6", "rd_data", rd_data, f_data[0]);
        end
        chk(rx_count == 2'(f_id.size()), "R6", "rx_count", 64'(rx_count), 64'(f_id.size()));
        chk(ovr_flag == m_ovr, "R9", "ovr_flag", 64'(ovr_flag), 64'(m_ovr));
    endtask

    task automatic step();
        @(negedge clk);
        if (rst_n) compare_all();
        ld_valid = 1'b0; tx_done = 1'b0; rx_valid = 1'b0; rd_pop = 1'b0; ovr_clr = 1'b0;
    endtask

    task automatic load(input int idx, input int id);
        ld_valid = 1'b1; ld_idx = 2'(idx); ld_id = 11'(id); ld_data = {32'hC0DE0000 | 32'(id), 32'(idx)};
        step();
    endtask

    task automatic done1(); tx_done = 1'b1; step(); endtask

    task automatic push(input int id);
        rx_valid = 1'b1; rx_id = 11'(id); rx_data = 64'hA5A5_0000_0000_0000 | 64'(id);
        step();
    endtask

    task automatic pop1(); rd_pop = 1'b1; step(); endtask

    task automatic exp_tx(input int idx, input string req);
        chk(tx_valid && tx_idx == 2'(idx), req, "presented mailbox", 64'(tx_idx), 64'(idx));
    endtask

    task automatic exp_head(input int id, input string req);
        chk(rd_valid && rd_id == 11'(id), req, "oldest entry", 64'(rd_id), 64'(id));
    endtask

    task automatic drain_tx();
        for (int n = 0; n < 8 && tx_valid; n++) done1();
    endtask

    task automatic drain_rx();
        for (int n = 0; n < 8 && rd_valid; n++) pop1();
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(mbox_pending == 3'b000 && !tx_valid, "R1", "tx idle after reset", 64'(mbox_pending), 64'd0);
        chk(!rd_valid && rx_count == 2'd0 && !ovr_flag, "R1", "rx idle after reset", 64'(rx_count), 64'd0);

        // R3 smallest identifier first
        cfg_tx_by_order = 1'b0;
        load(0, 'h300); load(1, 'h100); load(2, 'h200);
        exp_tx(1, "R3"); done1();
        exp_tx(2, "R3"); done1();
        exp_tx(0, "R3"); done1();
        chk(!tx_valid, "R5", "all mailboxes released", 64'(tx_valid), 64'd0);

        // R3 tie goes to lower index; R2 busy load ignored
        load(2, 'h50); load(1, 'h50);
        exp_tx(1, "R3");
        load(1, 'h10);
        chk(tx_id == 11'h50, "R2", "load into busy mailbox ignored", 64'(tx_id), 64'h50);
        load(0, 'h7FF); ld_valid = 1'b1; ld_idx = 2'd3; step();
        chk(mbox_pending == 3'b111, "R2", "index 3 load ignored", 64'(mbox_pending), 64'h7);
        repeat (4) step();
        chk(mbox_pending == 3'b111, "R5", "no release without done", 64'(mbox_pending), 64'h7);
        drain_tx();

        // R4 request order
        cfg_tx_by_order = 1'b1;
        load(2, 'h700); load(0, 'h001); load(1, 'h400);
        exp_tx(2, "R4"); done1();
        load(2, 'h000);
        exp_tx(0, "R4"); done1();
        exp_tx(1, "R4");
        // done and load in the same cycle
        tx_done = 1'b1; ld_valid = 1'b1; ld_idx = 2'd0; ld_id = 11'h123; ld_data = 64'h1; step();
        exp_tx(2, "R4"); done1();
        exp_tx(0, "R4"); done1();
        chk(!tx_valid, "R5", "order mode drained", 64'(tx_valid), 64'd0);

        // R7 replace newest
        cfg_rx_lock = 1'b0;
        for (int i = 1; i <= 5; i++) push(i);
        chk(ovr_flag, "R9", "flag after replace", 64'(ovr_flag), 64'd1);
        exp_head(1, "R7"); pop1(); exp_head(2, "R7"); pop1(); exp_head(5, "R7"); pop1();
        chk(!rd_valid, "R7", "store empty", 64'(rd_valid), 64'd0);
        ovr_clr = 1'b1; step();
        chk(!ovr_flag, "R9", "flag cleared", 64'(ovr_flag), 64'd0);

        // R8 lock and drop
        cfg_rx_lock = 1'b1;
        for (int i = 1; i <= 5; i++) push(i);
        exp_head(1, "R8"); pop1(); exp_head(2, "R8"); pop1(); exp_head(3, "R8"); pop1();
        chk(ovr_flag, "R9", "flag after drop", 64'(ovr_flag), 64'd1);
        // clear and loss in same cycle
        for (int i = 1; i <= 3; i++) push(i);
        ovr_clr = 1'b1; rx_valid = 1'b1; rx_id = 11'h9; step();
        chk(ovr_flag, "R9", "loss beats clear", 64'(ovr_flag), 64'd1);
        ovr_clr = 1'b1; step();
        drain_rx();

        // R6 pop on empty
        pop1(); pop1();
        push('h44);
        chk(rx_count == 2'd1, "R6", "count after empty pops", 64'(rx_count), 64'd1);
        exp_head('h44, "R6");
        drain_rx();

        // R10 push and pop together at full
        cfg_rx_lock = 1'b0;
        push(1); push(2); push(3);
        rd_pop = 1'b1; rx_valid = 1'b1; rx_id = 11'd4; rx_data = 64'hA5A5_0000_0000_0004; step();
        chk(!ovr_flag && rx_count == 2'd3, "R10", "no loss on swap", 64'(ovr_flag), 64'd0);
        exp_head(2, "R10"); pop1(); exp_head(3, "R10"); pop1(); exp_head(4, "R10"); pop1();

        // mixed random traffic against the model
        for (int c = 0; c < 4000; c++) begin
            if (c % 500 == 0) begin
                cfg_tx_by_order = 1'($urandom % 2);
                cfg_rx_lock     = 1'($urandom % 2);
            end
            ld_valid = ($urandom % 3) == 0;
            ld_idx   = 2'($urandom % 4);
            ld_id    = 11'($urandom % 8);
            ld_data  = {$urandom, $urandom};
            tx_done  = ($urandom % 3) == 0;
            rx_valid = ($urandom % 2) == 0;
            rx_id    = 11'($urandom);
            rx_data  = {$urandom, $urandom};
            rd_pop   = ($urandom % 3) == 0;
            ovr_clr  = ($urandom % 8) == 0;
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule